// File: doc/BRIEF.md
# Two-Phase Stored-Weight Trim Sequencer

This controller brings one analog weight-storage cell to a requested value through a digital view of that cell. It selects the cell through an address decoder. It then drives a coarse actuator that can only raise the stored value, and stops that phase once the readback is a set code margin above the target. A fine actuator that can only lower the value then takes over. It issues single lowering pulses, and after each one it waits a settle time and then takes a fresh readback. Because the coarse phase always ends above the target, the fine phase only has to move in one direction.

Before each pulse, the drive-level setpoint is loaded with the most recent readback code. This keeps the strength of each pulse close to the same as the cell moves. A run ends in one of three ways. It succeeds when the readback lies within a tolerance window around the target. It stops with an overshoot flag if a pulse drops the readback below that window; it does not start raising again by itself. It stops with a timeout flag once the pulse budget is used up. In every case the actuators are switched off, the cell is deselected and the setpoint goes back to mid-scale.

Readback codes arrive over a valid/ready stream. The sequencer raises `rb_ready` only when it wants a sample, and it holds `rb_ready` high until `rb_valid` arrives. A sample is taken only in a cycle where both are high. The converter may hold back `rb_valid` for any number of cycles, and the sequencer simply waits. Codes offered while `rb_ready` is low are ignored.

Top module: `trim_seq`

## Requirements
- R1: While a run is busy, `cell_sel` is one-hot, with bit `cell_addr` (the address latched at start) set. When idle, `cell_sel` is all zero.
- R2: In the coarse phase `raise_en` is held high and `rb_ready` is high. The phase ends at the first accepted readback of at least target + MARGIN. `raise_en` and `lower_pulse` are never high together.
- R3: Each `lower_pulse` lasts exactly one cycle. While it is high, `drive_set` equals the readback code accepted just before it.
- R4: After a pulse, or after the coarse phase ends, `rb_ready` stays low for at least SETTLE_CYC+1 cycles. Once raised, `rb_ready` stays high until a sample is accepted.
- R5: A run finishes with `done` when an accepted fine-phase readback r satisfies |r - target| <= TOL.
- R6: A fine-phase readback below target - TOL ends the run with `err_overshoot`, and `raise_en` is not raised again.
- R7: If MAX_PULSES pulses have been issued and the readback is still above the window, the run ends with `err_timeout`, after exactly MAX_PULSES pulses.
- R8: When a run ends, `busy` falls and `raise_en`, `lower_pulse` and `cell_sel` are low. `drive_set` is 2^(CODE_W-1). Exactly one of `done`, `err_overshoot` and `err_timeout` is high, and it stays high until the next start.
- R9: `start` while busy is ignored: the cell select and the running sequence are not changed.
- R10: After reset: not busy, no status flag, `drive_set` at mid-scale, no cell selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled while idle) |
| cell_addr | input | ADDR_W | Cell to trim |
| target | input | CODE_W | Target readback code |
| rb_code | input | CODE_W | Readback code |
| rb_valid | input | 1 | Readback code is valid |
| rb_ready | output | 1 | Sequencer wants a readback |
| cell_sel | output | N_CELLS | One-hot cell select |
| raise_en | output | 1 | Coarse raise actuator enable |
| lower_pulse | output | 1 | Fine lowering pulse |
| drive_set | output | CODE_W | Drive-level setpoint |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run converged |
| err_overshoot | output | 1 | Last run went below the window |
| err_timeout | output | 1 | Last run used up the pulse budget |

## Verification
Two pairs of events can land in the same cycle. The first pair is the settle timer running out and the readback handshake. A converter model that holds `rb_valid` low for several cycles after each pulse provokes this, and the run is judged by its settle gaps and its converged value. The second pair is a fresh `start` and a live run. A start with a different address is injected mid-run, and the run is judged by an unchanged cell select and by exactly one completion for each queued run.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_COARSE, ST_SETTLE, ST_SAMPLE, ST_EVAL, ST_PULSE
  } trim_state_e;

  typedef enum logic [1:0] {
    RES_NONE, RES_DONE, RES_OVER, RES_TIMEOUT
  } trim_result_e;
endpackage

// File: rtl/trim_decoder.sv
module trim_decoder #(
  parameter int N_CELLS = 16,
  parameter int ADDR_W  = 4
) (
  input  logic               en,
  input  logic [ADDR_W-1:0]  addr,
  output logic [N_CELLS-1:0] sel
);
  for (genvar i = 0; i < N_CELLS; i++) begin : g_sel
    assign sel[i] = en && (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/trim_settle_timer.sv
module trim_settle_timer #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic expired
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (kick)           cnt_q <= CW'(SETTLE_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0) && !kick;
endmodule

// File: rtl/trim_window.sv
module trim_window #(
  parameter int CODE_W = 12,
  parameter int MARGIN = 200,
  parameter int TOL    = 2
) (
  input  logic [CODE_W-1:0] target,
  input  logic [CODE_W-1:0] rb_now,
  input  logic [CODE_W-1:0] rb_last,
  output logic              reached_hi,
  output logic              in_win,
  output logic              below
);
  localparam int EW = CODE_W + 2;
  localparam logic [EW-1:0] FULL = EW'((1 << CODE_W) - 1);

  logic [EW-1:0] tgt_e, hi_raw, hi_thr, now_e, last_e;

  always_comb begin
    tgt_e      = EW'(target);
    now_e      = EW'(rb_now);
    last_e     = EW'(rb_last);
    hi_raw     = tgt_e + EW'(MARGIN);
    hi_thr     = (hi_raw > FULL) ? FULL : hi_raw;
    reached_hi = now_e >= hi_thr;
    below      = (last_e + EW'(TOL)) < tgt_e;
    in_win     = !below && (last_e <= tgt_e + EW'(TOL));
  end
endmodule

// File: rtl/trim_seq.sv
module trim_seq
  import trim_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int N_CELLS    = 16,
  parameter int MARGIN     = 200,
  parameter int TOL        = 2,
  parameter int SETTLE_CYC = 4,
  parameter int MAX_PULSES = 100
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [$clog2(N_CELLS)-1:0] cell_addr,
  input  logic [CODE_W-1:0]          target,
  input  logic [CODE_W-1:0]          rb_code,
  input  logic                       rb_valid,
  output logic                       rb_ready,
  output logic [N_CELLS-1:0]         cell_sel,
  output logic                       raise_en,
  output logic                       lower_pulse,
  output logic [CODE_W-1:0]          drive_set,
  output logic                       busy,
  output logic                       done,
  output logic                       err_overshoot,
  output logic                       err_timeout
);
  localparam int ADDR_W = $clog2(N_CELLS);
  localparam int PCNT_W = $clog2(MAX_PULSES + 1);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1 << (CODE_W - 1));

  trim_state_e        st_q, st_d;
  trim_result_e       res_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [CODE_W-1:0]  tgt_q, last_q, drive_q;
  logic [PCNT_W-1:0]  pcnt_q;
  logic               hs, reached_hi, in_win, below, expired, kick, budget_out;

  assign busy        = (st_q != ST_IDLE);
  assign raise_en    = (st_q == ST_COARSE);
  assign lower_pulse = (st_q == ST_PULSE);
  assign rb_ready    = (st_q == ST_COARSE) || (st_q == ST_SAMPLE);
  assign hs          = rb_ready && rb_valid;
  assign drive_set   = drive_q;
  assign budget_out  = (pcnt_q == PCNT_W'(MAX_PULSES));
  assign kick        = lower_pulse || (raise_en && hs && reached_hi);

  assign done          = (res_q == RES_DONE);
  assign err_overshoot = (res_q == RES_OVER);
  assign err_timeout   = (res_q == RES_TIMEOUT);

  trim_decoder #(.N_CELLS(N_CELLS), .ADDR_W(ADDR_W)) u_dec (
    .en(busy), .addr(addr_q), .sel(cell_sel)
  );

  trim_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick(kick), .expired(expired)
  );

  trim_window #(.CODE_W(CODE_W), .MARGIN(MARGIN), .TOL(TOL)) u_win (
    .target(tgt_q), .rb_now(rb_code), .rb_last(last_q),
    .reached_hi(reached_hi), .in_win(in_win), .below(below)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start) st_d = ST_COARSE;
      ST_COARSE: if (hs && reached_hi) st_d = ST_SETTLE;
      ST_SETTLE: if (expired) st_d = ST_SAMPLE;
      ST_SAMPLE: if (hs) st_d = ST_EVAL;
      ST_EVAL:   st_d = (in_win || below || budget_out) ? ST_IDLE : ST_PULSE;
      ST_PULSE:  st_d = ST_SETTLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      res_q   <= RES_NONE;
      addr_q  <= '0;
      tgt_q   <= '0;
      last_q  <= '0;
      drive_q <= MID;
      pcnt_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start) begin
        addr_q <= cell_addr;
        tgt_q  <= target;
        res_q  <= RES_NONE;
        pcnt_q <= '0;
      end
      if (st_q == ST_SAMPLE && hs) last_q <= rb_code;
      if (st_q == ST_EVAL) begin
        if (in_win) begin
          res_q <= RES_DONE;    drive_q <= MID;
        end else if (below) begin
          res_q <= RES_OVER;    drive_q <= MID;
        end else if (budget_out) begin
          res_q <= RES_TIMEOUT; drive_q <= MID;
        end else begin
          drive_q <= last_q;
          pcnt_q  <= pcnt_q + 1'b1;
        end
      end
    end
  end

  AST_ONEHOT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot(cell_sel)); // R1
  AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cell_sel == '0)); // R1
  AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(raise_en && lower_pulse)); // R2
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    lower_pulse |=> !lower_pulse); // R3
  AST_DRIVE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    lower_pulse |-> (drive_set == last_q)); // R3
  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !rb_ready); // R4
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_ready && !rb_valid) |=> rb_ready); // R4
  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    err_overshoot |-> !raise_en); // R6
  AST_PULSE_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= PCNT_W'(MAX_PULSES)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!raise_en && !lower_pulse && drive_set == MID)); // R8
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done, err_overshoot, err_timeout}) <= 1); // R8
  AST_HOLD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cell_sel)); // R9
endmodule

// File: tb/trim_seq_bench.sv
`timescale 1ns/1ps
module trim_seq_bench;
  localparam int CW = 12, NC = 16, MARGIN = 200, TOL = 2, SETTLE = 4, MAXP = 150;
  localparam int MID = 2048, CSTEP = 37;
  localparam int ST_DONE = 0, ST_OVER = 1, ST_TMO = 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic [3:0] cell_addr = '0;
  logic [CW-1:0] target = '0;
  logic [CW-1:0] rb_code;
  logic rb_valid, rb_ready, raise_en, lower_pulse, busy, done, err_overshoot, err_timeout;
  logic [NC-1:0] cell_sel;
  logic [CW-1:0] drive_set;

  always #4 clk = ~clk;

  trim_seq #(.CODE_W(CW), .N_CELLS(NC), .MARGIN(MARGIN), .TOL(TOL),
             .SETTLE_CYC(SETTLE), .MAX_PULSES(MAXP)) u_trim_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cell_addr(cell_addr), .target(target),
    .rb_code(rb_code), .rb_valid(rb_valid), .rb_ready(rb_ready), .cell_sel(cell_sel),
    .raise_en(raise_en), .lower_pulse(lower_pulse), .drive_set(drive_set), .busy(busy),
    .done(done), .err_overshoot(err_overshoot), .err_timeout(err_timeout));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural cell + converter
  int v = 0, ld_val = 0, ov_step = 0, stall_cnt = 0;
  bit ld = 0, use_ov = 0, stall_mode = 0;
  assign rb_code  = CW'(v);
  assign rb_valid = !(stall_mode && stall_cnt != 0);
  always @(posedge clk) begin
    if (ld) v <= ld_val;
    else if (raise_en) v <= (v + CSTEP > 4095) ? 4095 : v + CSTEP;
    else if (lower_pulse) begin
      int s;
      s = use_ov ? ov_step : 1 + (v >> 9);
      v <= (v - s < 0) ? 0 : v - s;
    end
    if (lower_pulse) stall_cnt <= 9;
    else if (stall_cnt > 0) stall_cnt <= stall_cnt - 1;
  end

  typedef struct { int addr; int tgt; int v0; int status; } exp_t;
  exp_t exp_q[$];

  task automatic run(input int addr, input int tgt, input int v0, input bit ov,
                     input int step, input bit stall, input int status);
    exp_t e;
    e.addr = addr; e.tgt = tgt; e.v0 = v0; e.status = status;
    exp_q.push_back(e);
    @(negedge clk);
    ld = 1; ld_val = v0; use_ov = ov; ov_step = step; stall_mode = stall;
    @(negedge clk);
    ld = 0; start = 1; cell_addr = 4'(addr); target = CW'(tgt);
    @(negedge clk);
    start = 0;
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
    if (status == ST_DONE) chk(done == 1'b1, "R8 done held", done, 1);
    if (status == ST_OVER) chk(err_overshoot == 1'b1, "R8 overshoot held", err_overshoot, 1);
    if (status == ST_TMO)  chk(err_timeout == 1'b1, "R8 timeout held", err_timeout, 1);
  endtask

  // monitor / scoreboard
  int cyc = 0, pulses = 0, last_kick = 0;
  bit busy_p = 0, raise_p = 0;
  always @(negedge clk) begin
    cyc++;
    if (busy && exp_q.size() > 0) begin
      if (!busy_p) pulses = 0;
      if (lower_pulse) begin
        chk(drive_set == CW'(v), "R3 drive tracks readback", drive_set, v);
        chk(cell_sel == NC'(1) << exp_q[0].addr, "R1 one-hot select", cell_sel, 1 << exp_q[0].addr);
        pulses++;
        last_kick = cyc;
      end
      if (raise_p && !raise_en) begin
        last_kick = cyc - 1;
        chk(v >= exp_q[0].tgt + MARGIN, "R2 coarse reached margin", v, exp_q[0].tgt + MARGIN);
        if (exp_q[0].v0 < exp_q[0].tgt + MARGIN)
          chk(v < exp_q[0].tgt + MARGIN + 2 * CSTEP, "R2 coarse stop prompt", v, exp_q[0].tgt + MARGIN);
      end
      if (rb_ready && rb_valid && !raise_en)
        chk(cyc - last_kick >= SETTLE + 1, "R4 settle gap", cyc - last_kick, SETTLE + 1);
    end
    if (busy_p && !busy) begin
      exp_t e;
      e = exp_q.pop_front();
      chk({raise_en, lower_pulse} == 2'b00, "R8 actuators off", {raise_en, lower_pulse}, 0);
      chk(cell_sel == '0, "R8 no select", cell_sel, 0);
      chk(drive_set == CW'(MID), "R8 mid-scale", drive_set, MID);
      chk({done, err_overshoot, err_timeout} == (3'b100 >> e.status), "R8 one status",
          {done, err_overshoot, err_timeout}, 3'b100 >> e.status);
      if (e.status == ST_DONE)
        chk(v >= e.tgt - TOL && v <= e.tgt + TOL, "R5 converged", v, e.tgt);
      if (e.status == ST_OVER)
        chk(v < e.tgt - TOL, "R6 below window", v, e.tgt - TOL);
      if (e.status == ST_TMO)
        chk(pulses == MAXP, "R7 pulse budget", pulses, MAXP);
    end
    busy_p = busy;
    raise_p = raise_en;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 1'b0, "R10 idle", busy, 0);
    chk({done, err_overshoot, err_timeout} == 3'b000, "R10 no flags", {done, err_overshoot, err_timeout}, 0);
    chk(drive_set == CW'(MID), "R10 mid-scale", drive_set, MID);
    chk(cell_sel == '0, "R10 no select", cell_sel, 0);
    run(3, 1500, 1000, 0, 0, 0, ST_DONE);
    fork
      run(5, 900, 200, 0, 0, 0, ST_DONE);
      begin
        repeat (120) @(negedge clk);
        start = 1; cell_addr = 4'd15; target = 12'd10;
        @(negedge clk);
        start = 0;
        repeat (2) @(negedge clk);
        chk(cell_sel == NC'(1) << 5, "R9 start ignored", cell_sel, 1 << 5);
      end
    join
    run(9, 2200, 2300, 0, 0, 1, ST_DONE);
    run(1, 1200, 1410, 1, 40, 0, ST_OVER);
    run(12, 1000, 1300, 1, 0, 0, ST_TMO);
    chk(exp_q.size() == 0, "R9 one completion per run", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule